// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the global register file of a DMA controller that serves up to twelve channels. A host reaches it through a small 32-bit register bus with byte addresses. Through it the host sets, for every channel, a transfer mode, a transfer direction and an interrupt enable. The host reads back each channel's engine state and its pending completion and error flags. The block drives a single interrupt line that is shared by all channels.

The channel engines are outside this block. They feed it completion pulses, error pulses and a 2-bit state per channel. The block returns each channel's mode and direction, a one-cycle start pulse and a one-cycle abort pulse. Channels 8 and up have their own control and status words, and their fields sit at different bit positions from those of the lower channels.

Software changes one channel's mode without reading the others first. It writes the code 3 into the mode fields of every channel it wants to leave alone, and the block keeps those modes unchanged.

Top module: `dma_ctl_regs`

## Requirements
- R1: Decode uses byte address bits [4:2]. Word 1 (0x04) is a 32-bit read/write scratch word. Word 5 (0x14) and word 7 (0x1C) read as zero. Read data is combinational and equals zero unless a read is requested (req_i=1, we_i=0).
- R2: Channels 0–7 each own a 4-bit slot at bits [4c+3:4c] of the word at 0x00. Bits [1:0] hold the mode (0 off, 1 scatter-gather, 2 single block), bit 2 holds the direction (1 memory to device) and bit 3 reads 0. After reset every mode and direction is 0, and mode_o/dir_o follow the stored values from the clock edge of the write.
- R3: Channels 8–11 use the same 4-bit slot layout in the word at 0x0C, in slot c−8. A write to that word does not touch channels 0–7.
- R4: A mode code of 3 in a slot leaves that channel's mode unchanged. The direction bit of every slot in the written word always loads.
- R5: Writing mode 1 or 2 to a channel whose state input is 0 (idle) gives start_o for that channel high for exactly the one cycle after the write edge. If the channel is not idle, the mode loads but no start pulse is given.
- R6: Writing mode 0 sets the channel's mode to 0 and gives abort_o high for the one cycle after the write edge.
- R7: The interrupt enable for channel c is bit c of the word at 0x08 for c<8, and bit c+8 for c≥8. All other bits of that word read 0.
- R8: A done pulse sets the channel's pending flag. An error pulse sets both its pending flag and its error flag. For c<8 these flags read at bits c and c+8 of the word at 0x10. For c≥8 they read at bits c−8 and c of the word at 0x18.
- R9: The channel state reads at bits [16+2k+1:16+2k] of the same status word, where k is c for c<8 and c−8 otherwise. Writes never change it.
- R10: Writing 1 to a flag bit in a status word clears that flag, and writing 0 leaves it alone. If a set and a clear land in the same cycle, the flag stays set.
- R11: irq_o is high exactly when some channel has both its pending flag and its interrupt enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| done_i | input | NUM_CH | Per-channel completion pulse |
| err_i | input | NUM_CH | Per-channel error pulse |
| state_i | input | 2*NUM_CH | Per-channel engine state, 0 = idle |
| mode_o | output | 2*NUM_CH | Per-channel mode |
| dir_o | output | NUM_CH | Per-channel direction |
| start_o | output | NUM_CH | Per-channel start pulse |
| abort_o | output | NUM_CH | Per-channel abort pulse |
| irq_o | output | 1 | Shared interrupt |

## Verification
Some properties are checked by assertions on every cycle:
- a kept mode code leaves the channel's mode unchanged;
- a start pulse only ever comes with a running mode;
- an abort pulse comes with mode 0 and never with a start;
- an error pulse leaves both flags set;
- a clear with no set in the same cycle empties the pending flag;
- with all enables off, the interrupt stays low.

The bench's scenarios are the only way to show that every field sits at its bit position in each word and that the upper channels use their own words. The same goes for a start being held back on a busy channel, a set beating a clear in the same cycle, and state fields that cannot be written.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned LO_CH     = 8;
  localparam int unsigned SLOT_W    = 4;
  localparam int unsigned ERR_OFS   = 8;
  localparam int unsigned STATE_LSB = 16;

  typedef enum logic [2:0] {
    W_CTL_LO = 3'd0, W_SCRATCH = 3'd1, W_IEN = 3'd2, W_CTL_HI = 3'd3,
    W_STS_LO = 3'd4, W_ZERO = 3'd5, W_STS_HI = 3'd6, W_NONE = 3'd7
  } word_e;

  typedef enum logic [1:0] {
    M_OFF = 2'd0, M_SG = 2'd1, M_SINGLE = 2'd2, M_KEEP = 2'd3
  } mode_e;

  function automatic int unsigned slot_of(int unsigned c);
    return (c < LO_CH) ? c : c - LO_CH;
  endfunction

  function automatic int unsigned ien_bit(int unsigned c);
    return (c < LO_CH) ? c : c + 8;
  endfunction

  function automatic int unsigned pend_bit(int unsigned c);
    return slot_of(c);
  endfunction

  function automatic int unsigned err_bit(int unsigned c);
    return slot_of(c) + ERR_OFS;
  endfunction

  function automatic int unsigned state_pos(int unsigned c);
    return STATE_LSB + 2 * slot_of(c);
  endfunction
endpackage

// File: rtl/dma_ch_ctrl.sv
module dma_ch_ctrl
  import dma_regs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] field_i,
  input  logic       idle_i,
  output logic [1:0] mode_o,
  output logic       dir_o,
  output logic       start_o,
  output logic       abort_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= M_OFF;
      dir_o   <= 1'b0;
      start_o <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      abort_o <= 1'b0;
      if (wr_i) begin
        dir_o <= field_i[2];
        case (mode_e'(field_i[1:0]))
          M_KEEP: ;
          M_OFF: begin
            mode_o  <= M_OFF;
            abort_o <= 1'b1;
          end
          default: begin
            mode_o  <= field_i[1:0];
            start_o <= idle_i;
          end
        endcase
      end
    end
  end

  p_keep_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && field_i[1:0] == M_KEEP) |=> (mode_o == $past(mode_o)));

  p_start_running_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (mode_o == M_SG || mode_o == M_SINGLE));

  p_abort_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (mode_o == M_OFF && !start_o));
endmodule

// File: rtl/dma_ch_flags.sv
module dma_ch_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic err_i,
  input  logic clr_pend_i,
  input  logic clr_err_i,
  output logic pend_o,
  output logic err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      // set wins over a same-cycle clear
      pend_o <= done_i | err_i | (pend_o & ~clr_pend_i);
      err_o  <= err_i | (err_o & ~clr_err_i);
    end
  end

  p_err_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> (pend_o && err_o));

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pend_i && !done_i && !err_i) |=> !pend_o);
endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge #(
  parameter int unsigned N = 12
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] ien_i,
  output logic         irq_o
);
  assign irq_o = |(pend_i & ien_i);
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_regs_pkg::*;
#(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic [NUM_CH-1:0]   done_i,
  input  logic [NUM_CH-1:0]   err_i,
  input  logic [2*NUM_CH-1:0] state_i,
  output logic [2*NUM_CH-1:0] mode_o,
  output logic [NUM_CH-1:0]   dir_o,
  output logic [NUM_CH-1:0]   start_o,
  output logic [NUM_CH-1:0]   abort_o,
  output logic                irq_o
);
  localparam int unsigned WSEL_LSB = 2;

  logic        wr_en, rd_en;
  word_e       wsel;
  logic [REG_W-1:0]  scratch_q;
  logic [NUM_CH-1:0] ien_q, pend, errf;
  logic        unused_ok;

  assign wsel      = word_e'(addr_i[WSEL_LSB +: 3]);
  assign wr_en     = req_i & we_i;
  assign rd_en     = req_i & ~we_i;
  assign unused_ok = ^{wdata_i, addr_i};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned SLOT = slot_of(c);
    localparam word_e CTL_W = (c < LO_CH) ? W_CTL_LO : W_CTL_HI;
    localparam word_e STS_W = (c < LO_CH) ? W_STS_LO : W_STS_HI;

    dma_ch_ctrl i_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en && wsel == CTL_W),
      .field_i (wdata_i[SLOT*SLOT_W +: 3]),
      .idle_i  (state_i[2*c +: 2] == 2'd0),
      .mode_o  (mode_o[2*c +: 2]),
      .dir_o   (dir_o[c]),
      .start_o (start_o[c]),
      .abort_o (abort_o[c])
    );

    dma_ch_flags i_flags (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .done_i     (done_i[c]),
      .err_i      (err_i[c]),
      .clr_pend_i (wr_en && wsel == STS_W && wdata_i[pend_bit(c)]),
      .clr_err_i  (wr_en && wsel == STS_W && wdata_i[err_bit(c)]),
      .pend_o     (pend[c]),
      .err_o      (errf[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      ien_q[c] <= 1'b0;
      else if (wr_en && wsel == W_IEN)  ien_q[c] <= wdata_i[ien_bit(c)];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          scratch_q <= '0;
    else if (wr_en && wsel == W_SCRATCH)  scratch_q <= wdata_i;
  end

  dma_irq_merge #(.N(NUM_CH)) i_irq (
    .pend_i (pend),
    .ien_i  (ien_q),
    .irq_o  (irq_o)
  );

  logic [REG_W-1:0] ctl_lo_v, ctl_hi_v, ien_v, sts_lo_v, sts_hi_v;

  always_comb begin
    ctl_lo_v = '0;
    ctl_hi_v = '0;
    ien_v    = '0;
    sts_lo_v = '0;
    sts_hi_v = '0;
    for (int unsigned c = 0; c < NUM_CH; c++) begin
      ien_v[ien_bit(c)] = ien_q[c];
      if (c < LO_CH) begin
        ctl_lo_v[slot_of(c)*SLOT_W +: 3] = {dir_o[c], mode_o[2*c +: 2]};
        sts_lo_v[pend_bit(c)]            = pend[c];
        sts_lo_v[err_bit(c)]             = errf[c];
        sts_lo_v[state_pos(c) +: 2]      = state_i[2*c +: 2];
      end else begin
        ctl_hi_v[slot_of(c)*SLOT_W +: 3] = {dir_o[c], mode_o[2*c +: 2]};
        sts_hi_v[pend_bit(c)]            = pend[c];
        sts_hi_v[err_bit(c)]             = errf[c];
        sts_hi_v[state_pos(c) +: 2]      = state_i[2*c +: 2];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      case (wsel)
        W_CTL_LO:  rdata_o = ctl_lo_v;
        W_SCRATCH: rdata_o = scratch_q;
        W_IEN:     rdata_o = ien_v;
        W_CTL_HI:  rdata_o = ctl_hi_v;
        W_STS_LO:  rdata_o = sts_lo_v;
        W_STS_HI:  rdata_o = sts_hi_v;
        default:   rdata_o = '0;
      endcase
    end
  end

  p_irq_needs_en_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);
endmodule

// File: tb/test_dma_ctl_regs.sv
module test_dma_ctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 12;

  logic clk = 0, rst_n = 1;
  logic req = 0, we = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] done = '0, err = '0;
  logic [2*NCH-1:0] st = '0;
  logic [2*NCH-1:0] mode;
  logic [NCH-1:0] dir, start, abort;
  logic irq;

  int n_run = 0, n_fail = 0;
  bit cmp_on = 0;

  dma_ctl_regs i_dma_ctl_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_i(done), .err_i(err),
    .state_i(st), .mode_o(mode), .dir_o(dir), .start_o(start),
    .abort_o(abort), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  int m_mode[NCH], m_dir[NCH], m_ien[NCH], m_pend[NCH], m_err[NCH];
  int m_start[NCH], m_abort[NCH];
  logic [31:0] m_scr;

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_mode[c] = 0; m_dir[c] = 0; m_ien[c] = 0; m_pend[c] = 0;
      m_err[c] = 0; m_start[c] = 0; m_abort[c] = 0;
    end
    m_scr = '0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      int w;
      w = int'(addr[4:2]);
      for (int c = 0; c < NCH; c++) begin
        int s, f, pb, eb, ib;
        s  = (c < 8) ? c : c - 8;
        pb = s; eb = s + 8;
        ib = (c < 8) ? c : c + 8;
        m_start[c] = 0; m_abort[c] = 0;
        if (req && we) begin
          if ((c < 8 && w == 0) || (c >= 8 && w == 3)) begin
            f = int'(wdata[4*s +: 4]);
            m_dir[c] = (f >> 2) & 1;
            if ((f & 3) == 0) begin m_mode[c] = 0; m_abort[c] = 1; end
            else if ((f & 3) != 3) begin
              m_mode[c] = f & 3;
              m_start[c] = (st[2*c +: 2] == 2'd0) ? 1 : 0;
            end
          end
          if (w == 2) m_ien[c] = int'(wdata[ib]);
          if ((c < 8 && w == 4) || (c >= 8 && w == 6)) begin
            if (wdata[pb]) m_pend[c] = 0;
            if (wdata[eb]) m_err[c] = 0;
          end
        end
        if (done[c] || err[c]) m_pend[c] = 1;
        if (err[c]) m_err[c] = 1;
      end
      if (req && we && w == 1) m_scr = wdata;
    end
  end

  function automatic logic [31:0] m_read();
    logic [31:0] v;
    int w;
    v = '0;
    w = int'(addr[4:2]);
    if (!(req && !we)) return v;
    if (w == 1) return m_scr;
    for (int c = 0; c < NCH; c++) begin
      int s;
      s = (c < 8) ? c : c - 8;
      if ((w == 0 && c < 8) || (w == 3 && c >= 8)) begin
        v[4*s +: 2] = 2'(m_mode[c]);
        v[4*s + 2]  = m_dir[c][0];
      end
      if (w == 2) v[(c < 8) ? c : c + 8] = m_ien[c][0];
      if ((w == 4 && c < 8) || (w == 6 && c >= 8)) begin
        v[s]            = m_pend[c][0];
        v[s + 8]        = m_err[c][0];
        v[16 + 2*s +: 2] = st[2*c +: 2];
      end
    end
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      logic [31:0] em_mode, em_dir, em_st, em_ab;
      logic eirq;
      #2;
      em_mode = '0; em_dir = '0; em_st = '0; em_ab = '0; eirq = 0;
      for (int c = 0; c < NCH; c++) begin
        em_mode[2*c +: 2] = 2'(m_mode[c]);
        em_dir[c] = m_dir[c][0];
        em_st[c]  = m_start[c][0];
        em_ab[c]  = m_abort[c][0];
        if (m_pend[c] != 0 && m_ien[c] != 0) eirq = 1;
      end
      chk("R2 mode_o", 32'(mode), em_mode);
      chk("R2 dir_o", 32'(dir), em_dir);
      chk("R5 start_o", 32'(start), em_st);
      chk("R6 abort_o", 32'(abort), em_ab);
      chk("R11 irq_o", 32'(irq), 32'(eirq));
      chk("R1 rdata_o", rdata, m_read());
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    #3; chk(tag, rdata, exp);
    @(negedge clk); req = 0;
  endtask

  task automatic pulse(logic [NCH-1:0] d, logic [NCH-1:0] e);
    @(negedge clk); done = d; err = e;
    @(negedge clk); done = '0; err = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1 rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R2 reset mode", 32'(mode), 32'h0);
    chk("R11 reset irq", 32'(irq), 32'h0);
    cmp_on = 1;
    rd(5'h00, 32'h0, "R2 reset ctl_lo");

    wr(5'h04, 32'hDEADBEEF);
    rd(5'h04, 32'hDEADBEEF, "R1 scratch");
    rd(5'h14, 32'h0, "R1 zero word");
    rd(5'h1C, 32'h0, "R1 unmapped");

    wr(5'h00, 32'h33333336);          // ch0 single block, mem->dev
    #3 chk("R5 start pulse ch0", 32'(start), 32'h1);
    @(negedge clk); #3 chk("R5 start ends", 32'(start), 32'h0);
    rd(5'h00, 32'h00000006, "R2 ctl_lo layout");

    wr(5'h00, 32'h33333333);          // keep all modes, clear ch0 dir
    rd(5'h00, 32'h00000002, "R4 keep mode");

    st[3:2] = 2'd2;                   // ch1 busy
    wr(5'h00, 32'h33333313);
    #3 chk("R5 no start busy", 32'(start), 32'h0);
    rd(5'h00, 32'h00000012, "R5 mode loads busy");

    wr(5'h00, 32'h33333330);
    #3 chk("R6 abort ch0", 32'(abort), 32'h1);
    rd(5'h00, 32'h00000010, "R6 mode off");

    wr(5'h0C, 32'h00003363);          // ch9 single block
    #3 chk("R3 start ch9", 32'(start), 32'h200);
    rd(5'h0C, 32'h00000060, "R3 ctl_hi layout");
    rd(5'h00, 32'h00000010, "R3 low untouched");

    wr(5'h08, 32'hFFFFFFFF);
    rd(5'h08, 32'h000F00FF, "R7 enable bits");

    pulse(12'h004, 12'h000);
    rd(5'h10, 32'h00080004, "R8 done flag");
    chk("R11 irq up", 32'(irq), 32'h1);
    pulse(12'h000, 12'h400);
    rd(5'h18, 32'h00000404, "R8 error flags hi");

    @(negedge clk); req = 1; we = 1; addr = 5'h10; wdata = 32'h0000000C; done = 12'h008;
    @(negedge clk); req = 0; we = 0; wdata = '0; done = '0;
    rd(5'h10, 32'h00080008, "R10 clear and set wins");

    wr(5'h08, 32'h0);
    #3 chk("R11 irq masked", 32'(irq), 32'h0);
    wr(5'h08, 32'h00040000);
    #3 chk("R11 irq ch10 enable", 32'(irq), 32'h1);

    wr(5'h10, 32'hFFFF0008);
    rd(5'h10, 32'h00080000, "R9 state read only");
    wr(5'h18, 32'h00000404);
    rd(5'h18, 32'h00000000, "R10 clear hi");
    #3 chk("R11 irq down", 32'(irq), 32'h0);

    repeat (2) @(negedge clk);
    cmp_on = 0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule